// File: doc/BRIEF.md
# Serial TDM Frame and Channel Timing Generator

This block derives the frame, channel and bit timing of an eight-line serial time-division-multiplexed port from a single serial clock and an 8 kHz frame pulse. Software selects one of three line rates: 2.048, 4.096 or 8.192 Mbit/s. At the two lower rates the clock runs at twice the bit rate, so every bit occupies two clock cycles. At the highest rate every bit occupies one clock cycle. The block reports the current channel number and bit position, with the most significant bit sent first. It also reports which of the eight streams are live at the selected rate.

The block works in one of two timing roles. As frame master it counts freely and drives the frame pulse itself, with a programmable active level. As frame slave it aligns its counters to an incoming frame pulse. It learns the pulse's active level by observing which level the line rests at, and it re-evaluates that level at every frame end. When a pulse arrives at an unexpected count, the block realigns its counters and latches a slip flag. A per-stream, per-channel direction table drives the output enable of each bidirectional serial line. The table is cleared at reset, so every line starts as an input.

Top module: `tdm_frame_timer`

## Requirements
- R1: After reset the outputs read as follows: channel 0, bit position 7, slip 0, detected format 0 (active-low), and all line enables 0. The direction table is cleared.
- R2: With rate code 0 (2.048 Mbit/s) a frame lasts 512 clocks and carries channels 0 to 31. Each bit holds for two clocks. The bit position counts down from 7 to 0, so the channel advances every 16 clocks.
- R3: With rate code 1 (4.096 Mbit/s) a frame lasts 1024 clocks and carries channels 0 to 63. Each bit holds for two clocks and the channel advances every 16 clocks.
- R4: With rate code 2 (8.192 Mbit/s) a frame lasts 1024 clocks and carries channels 0 to 127. Each bit holds for one clock and the channel advances every 8 clocks.
- R5: The stream-active mask is 8'hFF for rate codes 0 and 1 and 8'h0F for rate code 2. A line enable for an inactive stream is always 0.
- R6: A clocked write with write enable high, a stream index, a channel index and a data bit stores that bit in the direction table. A line's enable, bit s of line_oe, is 1 exactly while chan_num equals a channel whose stored bit for stream s is 1 and that stream is active.
- R7: In master mode fp_oe is 1. fp_out sits at the level of fp_pol only in the final clock of each frame, which is the last channel at bit position 0, and at the opposite level otherwise. fp_in has no effect on the counters or on slip.
- R8: In slave mode a frame start is a clock edge at which fp_in is at the active level after being at the inactive level at the previous edge. After a frame start the counters read frame position 0. A start that arrives while the counter sits at the frame's last count leaves slip at 0.
- R9: A slave frame start that arrives at any other count still realigns the counters to position 0, and it sets slip. Slip then stays at 1 until reset.
- R10: In slave mode, at each natural frame end, fmt_high becomes 1 if fp_in was sampled low more often than high since the previous evaluation, and becomes 0 otherwise. The active level is low when fmt_high is 0 and high when fmt_high is 1.
- R11: In slave mode fp_oe and fp_out are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Line rate: 0 = 2.048, 1 = 4.096, 2 = 8.192 Mbit/s |
| master_en | input | 1 | 1 = frame master, 0 = frame slave |
| fp_pol | input | 1 | Active level of the frame pulse in master mode |
| fp_in | input | 1 | Frame pulse input (used in slave mode) |
| fp_out | output | 1 | Frame pulse output (driven in master mode) |
| fp_oe | output | 1 | Output enable for the frame pulse pin |
| fmt_high | output | 1 | Detected frame pulse format: 0 = active-low, 1 = active-high |
| slip | output | 1 | Sticky flag for a misaligned frame start |
| dir_we | input | 1 | Direction table write enable |
| dir_stream | input | 3 | Stream index to write |
| dir_chan | input | 7 | Channel index to write |
| dir_out | input | 1 | Value to store: 1 = line drives in that channel |
| chan_num | output | 7 | Current channel number |
| bit_pos | output | 3 | Current bit position, 7 sent first |
| stream_act | output | 8 | Mask of streams live at the selected rate |
| line_oe | output | 8 | Per-line output enables for the current channel |

## Verification
The bench samples near channel and frame boundaries at every rate. A design that confused the two-clock bit timing with the one-clock bit timing would show the wrong channel after 8, 16 or 512 clocks. In slave mode, one pulse arrives on the last count and another arrives mid-frame. A design that flagged an aligned pulse, or that failed to restart its counters on a late pulse, would show a wrong slip value or a wrong channel afterwards. The active-high run starts from the active-low default, so the format must change at the first frame end. A design that inverted the majority test would never realign to the high pulse. Direction bits are written for a stream that goes inactive at 8.192 Mbit/s, which exposes a missing stream mask. In master mode stray pulses are fed in to show that they are ignored.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;

   typedef enum logic [1:0] {
      RATE_2M  = 2'd0,
      RATE_4M  = 2'd1,
      RATE_8M  = 2'd2,
      RATE_RSV = 2'd3
   } tdm_rate_e;

   // Two clocks per bit at the lower rates, one at the top rate.
   function automatic logic two_clk_bits(tdm_rate_e r);
      return (r != RATE_8M);
   endfunction

   function automatic int unsigned chans_at(tdm_rate_e r, int unsigned max_chans);
      case (r)
         RATE_4M: return max_chans / 2;
         RATE_8M: return max_chans;
         default: return max_chans / 4;
      endcase
   endfunction

   function automatic int unsigned frame_clocks(tdm_rate_e r, int unsigned max_chans,
                                                int unsigned chan_bits);
      int unsigned per_bit;
      per_bit = two_clk_bits(r) ? 2 : 1;
      return chans_at(r, max_chans) * chan_bits * per_bit;
   endfunction

endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] last_cnt,
   input  logic             resync,
   output logic [CNT_W-1:0] fcnt,
   output logic             at_last,
   output logic             slip
);
   localparam logic [CNT_W-1:0] STEP = 1;

   assign at_last = (fcnt >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt <= '0;
         slip <= 1'b0;
      end else if (resync) begin
         fcnt <= '0;
         if (!at_last) slip <= 1'b1;
      end else if (at_last) begin
         fcnt <= '0;
      end else begin
         fcnt <= fcnt + STEP;
      end
   end
endmodule

// File: rtl/tdm_fp_sense.sv
module tdm_fp_sense #(
   parameter int WIN_W = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic fp_in,
   input  logic eval,
   output logic fmt_high,
   output logic start
);
   localparam logic [WIN_W-1:0] ONE = 1;

   logic             fp_q;
   logic             primed;
   logic [WIN_W-1:0] hi_cnt;
   logic [WIN_W-1:0] lo_cnt;

   // Entry into the active level, qualified once a previous sample exists.
   assign start = enable && primed && (fp_in == fmt_high) && (fp_q != fmt_high);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fp_q     <= 1'b0;
         primed   <= 1'b0;
         hi_cnt   <= '0;
         lo_cnt   <= '0;
         fmt_high <= 1'b0;
      end else begin
         fp_q   <= fp_in;
         primed <= 1'b1;
         if (!enable) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
         end else if (eval) begin
            fmt_high <= (lo_cnt > hi_cnt);
            hi_cnt   <= '0;
            lo_cnt   <= '0;
         end else if (fp_in) begin
            if (hi_cnt != '1) hi_cnt <= hi_cnt + ONE;
         end else begin
            if (lo_cnt != '1) lo_cnt <= lo_cnt + ONE;
         end
      end
   end
endmodule

// File: rtl/tdm_dir_table.sv
module tdm_dir_table #(
   parameter int NUM_STREAMS = 8,
   parameter int MAX_CHANS   = 128,
   parameter int ST_W        = 3,
   parameter int CH_W        = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [ST_W-1:0]        wstream,
   input  logic [CH_W-1:0]        wchan,
   input  logic                   wdata,
   input  logic [CH_W-1:0]        rchan,
   input  logic [NUM_STREAMS-1:0] enable,
   output logic [NUM_STREAMS-1:0] oe
);
   for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
      logic [MAX_CHANS-1:0] dir_bits;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_bits <= '0;
         end else if (we && (wstream == ST_W'(s))) begin
            dir_bits[wchan] <= wdata;
         end
      end

      assign oe[s] = dir_bits[rchan] & enable[s];
   end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
   import tdm_timing_pkg::*;
#(
   parameter int NUM_STREAMS = 8,
   parameter int MAX_CHANS   = 128,
   parameter int CHAN_BITS   = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [1:0]                     rate_sel,
   input  logic                           master_en,
   input  logic                           fp_pol,
   input  logic                           fp_in,
   output logic                           fp_out,
   output logic                           fp_oe,
   output logic                           fmt_high,
   output logic                           slip,
   input  logic                           dir_we,
   input  logic [$clog2(NUM_STREAMS)-1:0] dir_stream,
   input  logic [$clog2(MAX_CHANS)-1:0]   dir_chan,
   input  logic                           dir_out,
   output logic [$clog2(MAX_CHANS)-1:0]   chan_num,
   output logic [$clog2(CHAN_BITS)-1:0]   bit_pos,
   output logic [NUM_STREAMS-1:0]         stream_act,
   output logic [NUM_STREAMS-1:0]         line_oe
);
   localparam int ST_W         = $clog2(NUM_STREAMS);
   localparam int CH_W         = $clog2(MAX_CHANS);
   localparam int BIT_W        = $clog2(CHAN_BITS);
   localparam int CNT_W        = CH_W + BIT_W;
   localparam int WIN_W        = CNT_W + 2;
   localparam int HALF_STREAMS = NUM_STREAMS / 2;

   if ((1 << CH_W) != MAX_CHANS || MAX_CHANS < 4) begin : g_bad_chans
      $error("MAX_CHANS must be a power of two of at least 4");
   end
   if ((1 << BIT_W) != CHAN_BITS || CHAN_BITS < 2) begin : g_bad_bits
      $error("CHAN_BITS must be a power of two of at least 2");
   end
   if ((1 << ST_W) != NUM_STREAMS || NUM_STREAMS < 2) begin : g_bad_streams
      $error("NUM_STREAMS must be a power of two of at least 2");
   end

   tdm_rate_e        rate;
   logic             slow;
   logic [CNT_W-1:0] last_cnt;
   logic [CNT_W-1:0] fcnt;
   logic             at_last;
   logic             start;
   logic [BIT_W-1:0] bit_idx;

   assign rate     = tdm_rate_e'(rate_sel);
   assign slow     = two_clk_bits(rate);
   assign last_cnt = CNT_W'(frame_clocks(rate, MAX_CHANS, CHAN_BITS) - 1);

   tdm_frame_counter #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .last_cnt(last_cnt),
      .resync  (start),
      .fcnt    (fcnt),
      .at_last (at_last),
      .slip    (slip)
   );

   tdm_fp_sense #(.WIN_W(WIN_W)) u_sense (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (!master_en),
      .fp_in   (fp_in),
      .eval    (at_last),
      .fmt_high(fmt_high),
      .start   (start)
   );

   // Position decode: the lowest count bit selects the half-bit at the slow rates.
   assign bit_idx  = slow ? fcnt[1 +: BIT_W] : fcnt[0 +: BIT_W];
   assign bit_pos  = ~bit_idx;
   assign chan_num = slow ? {1'b0, fcnt[BIT_W+1 +: CH_W-1]} : fcnt[BIT_W +: CH_W];

   // Master pulse occupies the final clock of the frame.
   assign fp_oe  = master_en;
   assign fp_out = master_en ? (at_last ? fp_pol : ~fp_pol) : 1'b0;

   for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_act
      if (s < HALF_STREAMS) begin : g_low
         assign stream_act[s] = 1'b1;
      end else begin : g_high
         assign stream_act[s] = (rate != RATE_8M);
      end
   end

   tdm_dir_table #(
      .NUM_STREAMS(NUM_STREAMS),
      .MAX_CHANS  (MAX_CHANS),
      .ST_W       (ST_W),
      .CH_W       (CH_W)
   ) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (dir_we),
      .wstream(dir_stream),
      .wchan  (dir_chan),
      .wdata  (dir_out),
      .rchan  (chan_num),
      .enable (stream_act),
      .oe     (line_oe)
   );
endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk #(
   parameter int NUM_STREAMS = 8,
   parameter int MAX_CHANS   = 128,
   parameter int CHAN_BITS   = 8
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [1:0]                     rate_sel,
   input logic                           master_en,
   input logic                           fp_pol,
   input logic                           fp_out,
   input logic                           fp_oe,
   input logic                           slip,
   input logic [$clog2(MAX_CHANS)-1:0]   chan_num,
   input logic [$clog2(CHAN_BITS)-1:0]   bit_pos,
   input logic [NUM_STREAMS-1:0]         line_oe
);
   localparam int CH_W  = $clog2(MAX_CHANS);
   localparam int BIT_W = $clog2(CHAN_BITS);
   localparam int HALF  = NUM_STREAMS / 2;
   localparam logic [BIT_W-1:0] ONE      = 1;
   localparam logic [CH_W-1:0]  LAST_2M  = CH_W'(MAX_CHANS / 4 - 1);
   localparam logic [CH_W-1:0]  LAST_4M  = CH_W'(MAX_CHANS / 2 - 1);
   localparam logic [CH_W-1:0]  LAST_8M  = CH_W'(MAX_CHANS - 1);

   logic [CH_W-1:0] last_chan;
   always_comb begin
      case (rate_sel)
         2'd1:    last_chan = LAST_4M;
         2'd2:    last_chan = LAST_8M;
         default: last_chan = LAST_2M;
      endcase
   end

   // R1: reset leaves every line as an input
   a_r1_oe_after_reset: assert property (@(posedge clk)
      !rst_n |=> line_oe == '0);

   // R2: channel stays inside the 2.048 range
   a_r2_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 2'd0) |-> (chan_num <= LAST_2M));

   // R3: channel stays inside the 4.096 range
   a_r3_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 2'd1) |-> (chan_num <= LAST_4M));

   // R2: bit position only ever steps down by one or wraps from 0 to 7 in master mode
   a_r2_bit_sequence: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && master_en && $past(master_en) && (bit_pos != $past(bit_pos)))
      |-> ((bit_pos == $past(bit_pos) - ONE) || ($past(bit_pos) == '0 && bit_pos == '1)));

   // R5: streams above the lower half never drive at 8.192
   a_r5_masked_streams: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 2'd2) |-> (line_oe[NUM_STREAMS-1:HALF] == '0));

   // R7: master pulse sits only on the last bit of the last channel
   a_r7_master_pulse_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (master_en && fp_oe && fp_out == fp_pol) |-> (bit_pos == '0 && chan_num == last_chan));

   // R9: slip is sticky until reset
   a_r9_slip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      slip |=> slip);

   // R11: nothing driven on the pulse pin while a slave
   a_r11_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |-> (!fp_oe && !fp_out));
endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(
   .NUM_STREAMS(NUM_STREAMS),
   .MAX_CHANS  (MAX_CHANS),
   .CHAN_BITS  (CHAN_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rate_sel (rate_sel),
   .master_en(master_en),
   .fp_pol   (fp_pol),
   .fp_out   (fp_out),
   .fp_oe    (fp_oe),
   .slip     (slip),
   .chan_num (chan_num),
   .bit_pos  (bit_pos),
   .line_oe  (line_oe)
);

// File: tb/test_tdm_frame_timer.sv
module test_tdm_frame_timer;
   localparam int K_CHAN = 0, K_BIT = 1, K_ACT = 2, K_OE = 3,
                  K_SLIP = 4, K_FMT = 5, K_FPO = 6, K_FPOE = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic       master_en = 1'b1;
   logic       fp_pol = 1'b1;
   logic       fp_in = 1'b1;
   logic       fp_out, fp_oe, fmt_high, slip;
   logic       dir_we = 1'b0;
   logic [2:0] dir_stream = '0;
   logic [6:0] dir_chan = '0;
   logic       dir_out = 1'b0;
   logic [6:0] chan_num;
   logic [2:0] bit_pos;
   logic [7:0] stream_act, line_oe;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      int    due;
      int    kind;
      int    exp;
      string req;
   } item_t;
   item_t sb[$];

   always #5 clk = ~clk;

   tdm_frame_timer i_tdm_frame_timer (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .master_en(master_en),
      .fp_pol(fp_pol), .fp_in(fp_in), .fp_out(fp_out), .fp_oe(fp_oe),
      .fmt_high(fmt_high), .slip(slip), .dir_we(dir_we), .dir_stream(dir_stream),
      .dir_chan(dir_chan), .dir_out(dir_out), .chan_num(chan_num), .bit_pos(bit_pos),
      .stream_act(stream_act), .line_oe(line_oe)
   );

   always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

   function automatic int observe(int kind);
      case (kind)
         K_CHAN:  return int'(chan_num);
         K_BIT:   return int'(bit_pos);
         K_ACT:   return int'(stream_act);
         K_OE:    return int'(line_oe);
         K_SLIP:  return int'(slip);
         K_FMT:   return int'(fmt_high);
         K_FPO:   return int'(fp_out);
         default: return int'(fp_oe);
      endcase
   endfunction

   // Monitor: pops expected items when their cycle comes round
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            int    act;
            it  = sb.pop_front();
            act = observe(it.kind);
            n_chk++;
            if (it.due != cyc || act != it.exp) begin
               n_fail++;
               $display("FAIL %s kind %0d at cycle %0d (due %0d): actual %0d expected %0d",
                        it.req, it.kind, cyc, it.due, act, it.exp);
            end
         end
      end
   end

   task automatic expect_at(int due, int kind, int exp, string req);
      sb.push_back('{due, kind, exp, req});
   endtask

   task automatic do_reset(logic [1:0] rate, logic mst, logic pol, logic fp_idle);
      @(negedge clk);
      rst_n     = 1'b0;
      rate_sel  = rate;
      master_en = mst;
      fp_pol    = pol;
      fp_in     = fp_idle;
      dir_we    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_cyc(int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic pulse_at(int n, logic lvl);
      wait_cyc(n);
      fp_in = lvl;
      @(negedge clk);
      fp_in = ~lvl;
   endtask

   task automatic write_dir(int n, int s, int c, logic v);
      wait_cyc(n);
      dir_we     = 1'b1;
      dir_stream = 3'(s);
      dir_chan   = 7'(c);
      dir_out    = v;
      @(negedge clk);
      dir_we = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      // Master, 2.048 Mbit/s, active-high pulse
      do_reset(2'd0, 1'b1, 1'b1, 1'b1);
      expect_at(0,   K_CHAN, 0,     "R1");
      expect_at(0,   K_BIT,  7,     "R1");
      expect_at(0,   K_SLIP, 0,     "R1");
      expect_at(0,   K_FMT,  0,     "R1");
      expect_at(0,   K_OE,   0,     "R1");
      expect_at(0,   K_ACT,  8'hFF, "R5");
      expect_at(0,   K_FPOE, 1,     "R7");
      expect_at(1,   K_BIT,  7,     "R2");
      expect_at(2,   K_BIT,  6,     "R2");
      expect_at(15,  K_BIT,  0,     "R2");
      expect_at(15,  K_CHAN, 0,     "R2");
      expect_at(16,  K_CHAN, 1,     "R2");
      expect_at(80,  K_OE,   8'h44, "R6");
      expect_at(95,  K_OE,   8'h44, "R6");
      expect_at(96,  K_OE,   8'h00, "R6");
      expect_at(216, K_CHAN, 13,    "R7");
      expect_at(216, K_SLIP, 0,     "R7");
      expect_at(510, K_FPO,  0,     "R7");
      expect_at(511, K_FPO,  1,     "R7");
      expect_at(511, K_CHAN, 31,    "R2");
      expect_at(512, K_FPO,  0,     "R7");
      expect_at(512, K_CHAN, 0,     "R2");
      expect_at(592, K_OE,   8'h44, "R6");
      write_dir(1, 2, 5, 1'b1);
      write_dir(2, 6, 5, 1'b1);
      pulse_at(200, 1'b0);
      pulse_at(205, 1'b1);
      fp_in = 1'b1;
      drain();

      // Master, 4.096 Mbit/s, active-low pulse
      do_reset(2'd1, 1'b1, 1'b0, 1'b1);
      expect_at(0,    K_ACT,  8'hFF, "R5");
      expect_at(16,   K_CHAN, 1,     "R3");
      expect_at(17,   K_BIT,  7,     "R3");
      expect_at(18,   K_BIT,  6,     "R3");
      expect_at(512,  K_CHAN, 32,    "R3");
      expect_at(1008, K_CHAN, 63,    "R3");
      expect_at(1022, K_FPO,  1,     "R7");
      expect_at(1023, K_FPO,  0,     "R7");
      expect_at(1023, K_BIT,  0,     "R3");
      expect_at(1024, K_CHAN, 0,     "R3");
      expect_at(1024, K_FPO,  1,     "R7");
      drain();

      // Master, 8.192 Mbit/s: upper streams masked
      do_reset(2'd2, 1'b1, 1'b1, 1'b1);
      expect_at(0,    K_ACT,  8'h0F, "R5");
      expect_at(1,    K_BIT,  6,     "R4");
      expect_at(7,    K_BIT,  0,     "R4");
      expect_at(8,    K_CHAN, 1,     "R4");
      expect_at(8,    K_BIT,  7,     "R4");
      expect_at(40,   K_OE,   8'h02, "R5");
      expect_at(48,   K_OE,   8'h00, "R6");
      expect_at(1023, K_CHAN, 127,   "R4");
      expect_at(1023, K_FPO,  1,     "R7");
      expect_at(1024, K_CHAN, 0,     "R4");
      write_dir(1, 6, 5, 1'b1);
      write_dir(2, 1, 5, 1'b1);
      drain();

      // Slave, active-low pulses, 2.048 Mbit/s
      do_reset(2'd0, 1'b0, 1'b0, 1'b1);
      expect_at(0,    K_FPOE, 0,  "R11");
      expect_at(0,    K_FPO,  0,  "R11");
      expect_at(0,    K_OE,   0,  "R1");
      expect_at(511,  K_CHAN, 31, "R8");
      expect_at(520,  K_SLIP, 0,  "R8");
      expect_at(520,  K_CHAN, 0,  "R8");
      expect_at(520,  K_BIT,  3,  "R8");
      expect_at(520,  K_FMT,  0,  "R10");
      expect_at(613,  K_CHAN, 0,  "R9");
      expect_at(613,  K_BIT,  7,  "R9");
      expect_at(613,  K_SLIP, 1,  "R9");
      expect_at(629,  K_CHAN, 1,  "R9");
      expect_at(1125, K_CHAN, 0,  "R9");
      expect_at(1200, K_SLIP, 1,  "R9");
      pulse_at(511, 1'b0);
      pulse_at(612, 1'b0);
      drain();

      // Slave, active-high pulses: format must be learned first
      do_reset(2'd0, 1'b0, 1'b0, 1'b0);
      expect_at(511,  K_FMT,  0, "R10");
      expect_at(512,  K_FMT,  1, "R10");
      expect_at(1030, K_SLIP, 0, "R8");
      expect_at(1030, K_FMT,  1, "R10");
      expect_at(1030, K_CHAN, 0, "R8");
      expect_at(1075, K_CHAN, 0, "R9");
      expect_at(1075, K_SLIP, 1, "R9");
      expect_at(1091, K_CHAN, 1, "R9");
      expect_at(1107, K_CHAN, 2, "R9");
      pulse_at(1023, 1'b1);
      pulse_at(1074, 1'b1);
      drain();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule